// File: doc/BRIEF.md
# Serial Link Power-State Manager

This block follows the low-power state of a serial storage link from the host side. The attached device asks for a low-power state by sending a power-management request, which arrives here already decoded. The host never refuses such a request and never asks for a low-power state of its own. The link's low-power states sit inside the controller's fully-on state, so the controller's own power state does not change.

There are two shallow states. PARTIAL wakes up quickly. SLUMBER saves more power but wakes up slowly. When host traffic needs the link while it sleeps, the block raises a wake request toward the out-of-band signalling logic. It holds the host's transaction back until the PHY reports that it is ready again.

If the PHY does not become ready within a set number of cycles, the block raises a sticky link-error flag. The limit is a separate parameter for PARTIAL and for SLUMBER. The device may also wake the link itself; the block sees this as PHY-ready rising.

Top module: `link_pm_ctrl`

## Requirements
- R1: While `rst` is high at a clock edge, the next cycle shows `pwr_state` = 0 (READY) and `pm_ack`, `wake_req`, `xact_gnt` and `link_err` all low.
- R2: A request (`pm_req_vld` high; `pm_req_slumber` 0 selects PARTIAL, 1 selects SLUMBER) sampled in READY with `xact_req` low gives the following:
  - In the next cycle, a one-cycle `pm_ack` pulse.
  - In the same cycle as the pulse, `pwr_state` = 1 (PARTIAL) or 2 (SLUMBER).
- R3: A request that arrives while `xact_req` is high, or while the link is not READY, is kept and never dropped. It is acknowledged in the cycle after the first edge that finds the link READY with `xact_req` low. A newer request replaces the kind of a kept one.
- R4: `pwr_state` leaves READY only in the cycle in which `pm_ack` is high.
- R5: An edge that samples `xact_req` high in PARTIAL or SLUMBER (without a PHY-ready rise) does two things in the next cycle:
  - It sets `pwr_state` = 3.
  - It raises `wake_req`, which stays high until `phy_rdy` is sampled high or the timeout expires.
- R6: `xact_gnt` is low while `wake_req` is high. After the edge that samples `phy_rdy` high during a wake, `pwr_state` is 0, `wake_req` is low and `xact_gnt` is high, provided `xact_req` is held.
- R7: If `phy_rdy` stays low, `wake_req` is high for exactly `PARTIAL_WAKE_CYC` cycles (wake from PARTIAL) or `SLUMBER_WAKE_CYC` cycles (wake from SLUMBER). In the next cycle:
  - `link_err` rises, and it stays high until reset.
  - `wake_req` falls.
  - `pwr_state` stays 3.
- R8: A rising edge of `phy_rdy` (low at the previous edge, high now) sampled in PARTIAL, SLUMBER or the failed state returns `pwr_state` to 0 in the next cycle, without `wake_req` ever asserting.
- R9: In READY, `xact_gnt` follows `xact_req` one cycle later. `xact_gnt` is never high unless `pwr_state` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| pm_req_vld | input | 1 | Decoded power-management request from the device, one cycle per request |
| pm_req_slumber | input | 1 | Kind of request: 0 PARTIAL, 1 SLUMBER |
| phy_rdy | input | 1 | PHY reports the link is up |
| xact_req | input | 1 | Host transaction needs the link; held until done |
| pm_ack | output | 1 | One-cycle acknowledge of a device request |
| wake_req | output | 1 | Request to send the wake out-of-band signal |
| xact_gnt | output | 1 | Host transaction may use the link |
| link_err | output | 1 | Sticky flag: wake did not complete in time |
| pwr_state | output | 2 | 0 READY, 1 PARTIAL, 2 SLUMBER, 3 waking or failed |

## Verification
The in-module properties watch several rules on every cycle:
- `pm_ack` is only a single-cycle pulse, issued from an idle READY link.
- The link never leaves READY without an acknowledge.
- A wake starts only from a low-power state with traffic pending.
- Grant never overlaps a wake or a non-READY state.
- The error flag, once set, stays set.

The directed scenarios show what depends on exact counts and orderings:
- the exact length of each wake window;
- a request deferred behind traffic or a sleeping link being acknowledged later with the latest kind;
- the grant appearing in the cycle after PHY-ready;
- a device-started wake that never raises `wake_req`.

// File: rtl/link_pm_ctrl.sv
module link_pm_ctrl #(
  parameter int unsigned PARTIAL_WAKE_CYC = 4,
  parameter int unsigned SLUMBER_WAKE_CYC = 500000
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       pm_req_vld,
  input  logic       pm_req_slumber,
  input  logic       phy_rdy,
  input  logic       xact_req,
  output logic       pm_ack,
  output logic       wake_req,
  output logic       xact_gnt,
  output logic       link_err,
  output logic [1:0] pwr_state
);

  localparam int unsigned MAXC = (PARTIAL_WAKE_CYC > SLUMBER_WAKE_CYC) ?
                                 PARTIAL_WAKE_CYC : SLUMBER_WAKE_CYC;
  localparam int unsigned CW = $clog2(MAXC + 1);
  localparam logic [CW-1:0] P_LD = CW'(PARTIAL_WAKE_CYC - 1);
  localparam logic [CW-1:0] S_LD = CW'(SLUMBER_WAKE_CYC - 1);

  typedef enum logic [2:0] {S_RDY, S_PART, S_SLUM, S_WAKE, S_FAIL} st_e;

  st_e          st, st_n;
  logic         pend, pend_slum, phy_q;
  logic [CW-1:0] cnt;

  wire req_any  = pm_req_vld | pend;
  wire req_slum = pm_req_vld ? pm_req_slumber : pend_slum;
  wire phy_rise = phy_rdy & ~phy_q;
  wire go_idle  = (st == S_RDY) && !xact_req && req_any;

  always_comb begin
    st_n = st;
    case (st)
      S_RDY:         if (go_idle) st_n = req_slum ? S_SLUM : S_PART;
      S_PART, S_SLUM: if (phy_rise) st_n = S_RDY;
                     else if (xact_req) st_n = S_WAKE;
      S_WAKE:        if (phy_rdy) st_n = S_RDY;
                     else if (cnt == '0) st_n = S_FAIL;
      S_FAIL:        if (phy_rise) st_n = S_RDY;
      default:       st_n = S_RDY;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      st        <= S_RDY;
      pend      <= 1'b0;
      pend_slum <= 1'b0;
      phy_q     <= 1'b0;
      cnt       <= '0;
      pm_ack    <= 1'b0;
      xact_gnt  <= 1'b0;
      link_err  <= 1'b0;
    end else begin
      st       <= st_n;
      phy_q    <= phy_rdy;
      pm_ack   <= go_idle;
      xact_gnt <= (st_n == S_RDY) && xact_req;
      if (go_idle) pend <= 1'b0;
      else if (pm_req_vld) begin
        pend      <= 1'b1;
        pend_slum <= pm_req_slumber;
      end
      if (st_n == S_WAKE && st != S_WAKE) cnt <= (st == S_SLUM) ? S_LD : P_LD;
      else if (st == S_WAKE && cnt != '0) cnt <= cnt - 1'b1;
      if (st == S_WAKE && st_n == S_FAIL) link_err <= 1'b1;
    end
  end

  assign wake_req  = (st == S_WAKE);
  assign pwr_state = (st == S_RDY)  ? 2'd0 :
                     (st == S_PART) ? 2'd1 :
                     (st == S_SLUM) ? 2'd2 : 2'd3;

  a_r2_ack_single: assert property (@(posedge clk) disable iff (rst)
    pm_ack |=> !pm_ack);
  a_r3_ack_from_idle: assert property (@(posedge clk) disable iff (rst)
    pm_ack |-> $past(pwr_state == 2'd0 && !xact_req));
  a_r4_no_host_entry: assert property (@(posedge clk) disable iff (rst)
    (pwr_state == 2'd0) |=> (pwr_state == 2'd0 || pm_ack));
  a_r5_wake_from_lp: assert property (@(posedge clk) disable iff (rst)
    $rose(wake_req) |-> $past((pwr_state == 2'd1 || pwr_state == 2'd2) && xact_req));
  a_r6_no_gnt_in_wake: assert property (@(posedge clk) disable iff (rst)
    wake_req |-> !xact_gnt);
  a_r9_gnt_only_ready: assert property (@(posedge clk) disable iff (rst)
    xact_gnt |-> (pwr_state == 2'd0));
  a_r7_err_sticky: assert property (@(posedge clk) disable iff (rst)
    link_err |=> link_err);
  a_r7_err_ends_wake: assert property (@(posedge clk) disable iff (rst)
    $rose(link_err) |-> (!wake_req && $past(wake_req)));

endmodule

// File: tb/link_pm_ctrl_tb_top.sv
module link_pm_ctrl_tb_top;
  localparam int PW = 3;
  localparam int SW = 7;

  logic clk = 1'b0, rst = 1'b1;
  logic pm_req_vld = 0, pm_req_slumber = 0, phy_rdy = 0, xact_req = 0;
  logic pm_ack, wake_req, xact_gnt, link_err;
  logic [1:0] pwr_state;
  int n_chk = 0, n_bad = 0, cyc = 0;

  always #10 clk = ~clk;

  link_pm_ctrl #(.PARTIAL_WAKE_CYC(PW), .SLUMBER_WAKE_CYC(SW)) dut_i (
    .clk(clk), .rst(rst), .pm_req_vld(pm_req_vld), .pm_req_slumber(pm_req_slumber),
    .phy_rdy(phy_rdy), .xact_req(xact_req), .pm_ack(pm_ack), .wake_req(wake_req),
    .xact_gnt(xact_gnt), .link_err(link_err), .pwr_state(pwr_state));

  task automatic tick();
    @(negedge clk);
  endtask

  task automatic chk(string req, int act, int exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: got %0d expected %0d (t=%0t)", req, act, exp, $time);
    end
  endtask

  task automatic outs(string req, int st, int ack, int wk, int gnt, int err);
    chk({req, " state"}, int'(pwr_state), st);
    chk({req, " ack"}, int'(pm_ack), ack);
    chk({req, " wake"}, int'(wake_req), wk);
    chk({req, " gnt"}, int'(xact_gnt), gnt);
    chk({req, " err"}, int'(link_err), err);
  endtask

  task automatic do_reset();
    rst = 1; pm_req_vld = 0; xact_req = 0; phy_rdy = 0;
    tick(); tick();
    rst = 0;
    outs("R1 reset", 0, 0, 0, 0, 0);
  endtask

  task automatic request(bit slum);
    pm_req_vld = 1; pm_req_slumber = slum;
    tick();
    pm_req_vld = 0;
  endtask

  task automatic t_partial_entry_and_wake();
    phy_rdy = 0;
    request(0);
    outs("R2 partial entry", 1, 1, 0, 0, 0);
    tick();
    outs("R2 ack pulse ends", 1, 0, 0, 0, 0);
    xact_req = 1; tick();
    outs("R5 wake issued", 3, 0, 1, 0, 0);
    tick();
    outs("R6 gnt held during wake", 3, 0, 1, 0, 0);
    phy_rdy = 1; tick();
    outs("R6 gnt after phy ready", 0, 0, 0, 1, 0);
    xact_req = 0; tick();
    outs("R9 gnt follows req", 0, 0, 0, 0, 0);
  endtask

  task automatic t_deferred_then_slumber_timeout();
    xact_req = 1; tick();
    outs("R9 gnt in ready", 0, 0, 0, 1, 0);
    request(0);
    outs("R3 deferred while busy", 0, 0, 0, 1, 0);
    pm_req_vld = 1; pm_req_slumber = 1; phy_rdy = 0; tick();
    pm_req_vld = 0;
    outs("R3 newer kind still deferred", 0, 0, 0, 1, 0);
    xact_req = 0; tick();
    outs("R3 deferred ack slumber", 2, 1, 0, 0, 0);
    tick();
    xact_req = 1; tick();
    outs("R5 wake from slumber", 3, 0, 1, 0, 0);
    for (int i = 2; i <= SW; i++) begin
      tick();
      chk("R7 slumber wake window", int'(wake_req), 1);
    end
    tick();
    outs("R7 slumber timeout", 3, 0, 0, 0, 1);
    tick();
    outs("R7 err sticky", 3, 0, 0, 0, 1);
    phy_rdy = 1; tick();
    outs("R8 recover from fail", 0, 0, 0, 1, 1);
    xact_req = 0; tick();
  endtask

  task automatic t_device_wake();
    phy_rdy = 1; tick();
    pm_req_vld = 1; pm_req_slumber = 0; phy_rdy = 0; tick();
    pm_req_vld = 0;
    outs("R2 entry for device wake", 1, 1, 0, 0, 0);
    tick(); tick();
    outs("R4 stays low power", 1, 0, 0, 0, 0);
    phy_rdy = 1; tick();
    outs("R8 device wake", 0, 0, 0, 0, 0);
    tick();
    outs("R8 stays ready", 0, 0, 0, 0, 0);
  endtask

  task automatic t_partial_timeout_and_lp_request();
    phy_rdy = 0;
    request(0);
    outs("R2 partial again", 1, 1, 0, 0, 0);
    request(1);
    outs("R3 request while asleep", 1, 0, 0, 0, 0);
    xact_req = 1; tick();
    outs("R5 partial wake", 3, 0, 1, 0, 0);
    for (int i = 2; i <= PW; i++) begin
      tick();
      chk("R7 partial wake window", int'(wake_req), 1);
    end
    tick();
    outs("R7 partial timeout", 3, 0, 0, 0, 1);
    phy_rdy = 1; tick();
    outs("R8 rise leaves fail", 0, 0, 0, 1, 1);
    xact_req = 0; tick();
    outs("R3 kept request acked", 2, 1, 0, 0, 1);
  endtask

  initial begin
    do_reset();
    t_partial_entry_and_wake();
    t_deferred_then_slumber_timeout();
    do_reset();
    t_device_wake();
    t_partial_timeout_and_lp_request();
    do_reset();
    $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  always @(posedge clk) begin
    cyc++;
    if (cyc > 20000) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog: got %0d cycles expected fewer", cyc);
      $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  end
endmodule